// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster control signals for a display pipe: horizontal sync, vertical sync, a data-enable strobe and a one-cycle frame-start marker. It runs entirely in the pixel clock domain. Software programs eight timing registers, four per axis, that give the length of each segment of a line (in pixels) or of a frame (in lines). Each value is written as the segment length minus one. A command bit starts and stops the raster, and a polarity register chooses the active level of each output.

A frame-start event sets a sticky status bit. The bit drives an interrupt line through a mask, and software clears it by writing a one to a clear register. The intended sequence is to stop the raster, reprogram the timing, then start it again. While stopped, both position counters are held at zero and every output rests at its inactive level.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the command bit, the mask and the status are 0, the polarity register reads 0x1F and all timing registers read 0. The sync, data-enable, frame-start and interrupt outputs are low.
- R2: Register map. Address 0 is the command (bit 0), 1 is polarity (bits 4:0), 2 is the mask (bit 0), 3 is the status (bit 0, read only) and 4 is the clear register (bit 0, write only). Addresses 8 to 15 hold the timing registers in this order: horizontal sync, back porch, active, front porch, then the same four for the vertical axis. Each timing register reads back the value written to it.
- R3: Each line is sync, back porch, active, front porch. A segment whose register holds N lasts N+1 pixels. Horizontal sync is active for the first (hsync+1) pixels of every line.
- R4: Each frame uses the same order counted in lines. Vertical sync is active for every pixel of the first (vsync+1) lines.
- R5: Data enable is active only when the horizontal position and the vertical position are both in their active segments.
- R6: Polarity bit 0 sets hsync, bit 1 vsync and bit 2 data enable, where 1 means active-high and 0 means active-low. Bit 3 appears on data_pol_o and bit 4 on pclk_pol_o.
- R7: Writing 1 to the command register starts the raster from position zero on the next cycle. frame_start_o is high for exactly the first pixel of each frame.
- R8: Writing 0 to the command register zeroes both counters. The outputs go to their inactive levels, frame_start_o stays low and the status bit is not set.
- R9: The status bit becomes 1 on the clock edge that ends a frame-start cycle, and it stays set.
- R10: irq_o equals status AND mask.
- R11: A write to the clear register with bit 0 set clears the status. A write with bit 0 clear has no effect.
- R12: If a frame-start event and a clearing write fall in the same cycle, the status is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| frame_start_o | output | 1 | Active-high pulse on the first pixel of each frame |
| irq_o | output | 1 | Masked frame interrupt |
| data_pol_o | output | 1 | Data polarity select for downstream logic |
| pclk_pol_o | output | 1 | Pixel clock polarity select for downstream logic |

## Verification
Two functions can act on the status bit in the same clock edge: setting it from a frame-start event and clearing it from a software write. To force the collision, the bench re-enables the raster and presents a clear write in the very cycle that frame_start_o first rises. The status is then read back and irq_o is observed with the mask set. Both must show the bit still set. A separate clear write, placed away from any frame start, must drop the status and the interrupt.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int AW     = 4;
    localparam int NSEG   = 4;
    localparam int NTIM   = 2 * NSEG;
    localparam int TIM_IW = $clog2(NTIM);
    localparam int POL_W  = 5;

    localparam logic [AW-1:0] A_CMD  = 4'h0;
    localparam logic [AW-1:0] A_POL  = 4'h1;
    localparam logic [AW-1:0] A_MASK = 4'h2;
    localparam logic [AW-1:0] A_STAT = 4'h3;
    localparam logic [AW-1:0] A_CLR  = 4'h4;
    localparam logic [AW-1:0] A_TIM0 = 4'h8;

    localparam int P_HS  = 0;
    localparam int P_VS  = 1;
    localparam int P_DE  = 2;
    localparam int P_DAT = 3;
    localparam int P_CLK = 4;

    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACT   = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;
endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            run_i,
    input  logic                            step_i,
    input  logic [NSEG-1:0][CNT_W-1:0]      len_i,
    output logic [CNT_W+2:0]                pos_o,
    output seg_e                            seg_o,
    output logic                            wrap_o
);
    localparam int POS_W = CNT_W + 3;

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } ax_st_t;

    ax_st_t s_q, s_d;
    logic [NSEG-1:0][POS_W-1:0] seg_end;
    logic [POS_W-1:0] last_pos;

    // Exclusive end position of each segment, accumulated in line order.
    always_comb begin
        logic [POS_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NSEG; i++) begin
            acc = acc + POS_W'(len_i[i]) + POS_W'(1);
            seg_end[i] = acc;
        end
    end

    assign last_pos = seg_end[NSEG-1] - POS_W'(1);

    always_comb begin
        seg_o = SEG_FRONT;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (s_q.pos < seg_end[i]) seg_o = seg_e'(2'(i));
        end
    end

    assign wrap_o = run_i && step_i && (s_q.pos == last_pos);
    assign pos_o  = s_q.pos;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d.pos = '0;
        end else if (step_i) begin
            s_d.pos = wrap_o ? '0 : s_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R8: a stopped axis sits at position zero
    a_r8_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (pos_o == '0));

    // R3: the position returns to zero after the last position of the period
    a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && wrap_o) |=> (pos_o == '0));

    // R3: the active segment is always entered from the back porch
    a_r3_seg_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i) && seg_o == SEG_ACT && $past(seg_o) != SEG_ACT)
            |-> ($past(seg_o) == SEG_BACK));
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DW    = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [DW-1:0]               wdata_i,
    input  logic                        frame_evt_i,
    output logic                        en_o,
    output logic [POL_W-1:0]            pol_o,
    output logic                        mask_o,
    output logic                        status_o,
    output logic [NTIM-1:0][CNT_W-1:0]  tim_o,
    output logic [DW-1:0]               rdata_o
);
    typedef struct packed {
        logic                       en;
        logic [POL_W-1:0]           pol;
        logic                       mask;
        logic                       status;
        logic [NTIM-1:0][CNT_W-1:0] tim;
    } rg_st_t;

    localparam rg_st_t RST_VAL = '{en: 1'b0, pol: '1, mask: 1'b0, status: 1'b0, tim: '0};

    rg_st_t s_q, s_d;
    logic [TIM_IW-1:0] tidx;
    logic is_tim;
    logic clr_hit;
    logic unused_wdata;

    assign tidx         = addr_i[TIM_IW-1:0];
    assign is_tim       = (addr_i >= A_TIM0);
    assign clr_hit      = wr_i && (addr_i == A_CLR) && wdata_i[0];
    assign unused_wdata = ^wdata_i[DW-1:CNT_W];

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            case (addr_i)
                A_CMD:   s_d.en   = wdata_i[0];
                A_POL:   s_d.pol  = wdata_i[POL_W-1:0];
                A_MASK:  s_d.mask = wdata_i[0];
                default: begin
                    if (is_tim) s_d.tim[tidx] = wdata_i[CNT_W-1:0];
                end
            endcase
        end
        if (clr_hit)     s_d.status = 1'b0;
        if (frame_evt_i) s_d.status = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= RST_VAL;
        else         s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CMD:   rdata_o[0]         = s_q.en;
            A_POL:   rdata_o[POL_W-1:0] = s_q.pol;
            A_MASK:  rdata_o[0]         = s_q.mask;
            A_STAT:  rdata_o[0]         = s_q.status;
            default: begin
                if (is_tim) rdata_o[CNT_W-1:0] = s_q.tim[tidx];
            end
        endcase
    end

    assign en_o     = s_q.en;
    assign pol_o    = s_q.pol;
    assign mask_o   = s_q.mask;
    assign status_o = s_q.status;
    assign tim_o    = s_q.tim;

    // R9: a frame event always leaves the status set
    a_r9_status_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_evt_i |=> status_o);

    // R12: set beats clear in the same cycle
    a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_evt_i && clr_hit) |=> status_o);

    // R11: a clearing write without an event drops the status
    a_r11_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_hit && !frame_evt_i) |=> !status_o);

    // R8: a stopped raster never raises the status
    a_r8_idle_no_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_o && !status_o) |=> !status_o);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DW    = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          frame_start_o,
    output logic          irq_o,
    output logic          data_pol_o,
    output logic          pclk_pol_o
);
    logic                       run;
    logic [POL_W-1:0]           pol;
    logic                       mask;
    logic                       status;
    logic [NTIM-1:0][CNT_W-1:0] tim;
    logic                       frame_evt;

    logic [CNT_W+2:0] h_pos, v_pos;
    seg_e             h_seg, v_seg;
    logic             h_wrap, v_wrap;
    logic             unused_vwrap;
    logic             hs_act, vs_act, de_act;

    rtg_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .frame_evt_i (frame_evt),
        .en_o        (run),
        .pol_o       (pol),
        .mask_o      (mask),
        .status_o    (status),
        .tim_o       (tim),
        .rdata_o     (reg_rdata_o)
    );

    rtg_axis #(.CNT_W(CNT_W)) u_h_axis (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .step_i (1'b1),
        .len_i  (tim[NSEG-1:0]),
        .pos_o  (h_pos),
        .seg_o  (h_seg),
        .wrap_o (h_wrap)
    );

    rtg_axis #(.CNT_W(CNT_W)) u_v_axis (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .step_i (h_wrap),
        .len_i  (tim[NTIM-1:NSEG]),
        .pos_o  (v_pos),
        .seg_o  (v_seg),
        .wrap_o (v_wrap)
    );

    assign unused_vwrap = v_wrap;

    assign frame_evt = run && (h_pos == '0) && (v_pos == '0);
    assign hs_act    = run && (h_seg == SEG_SYNC);
    assign vs_act    = run && (v_seg == SEG_SYNC);
    assign de_act    = run && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);

    assign hsync_o       = pol[P_HS] ? hs_act : !hs_act;
    assign vsync_o       = pol[P_VS] ? vs_act : !vs_act;
    assign de_o          = pol[P_DE] ? de_act : !de_act;
    assign frame_start_o = frame_evt;
    assign irq_o         = status && mask;
    assign data_pol_o    = pol[P_DAT];
    assign pclk_pol_o    = pol[P_CLK];
endmodule

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        hsync, vsync, de, fs, irq, dpol, cpol;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    raster_timing_gen dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .reg_wr_i      (wr_en),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .hsync_o       (hsync),
        .vsync_o       (vsync),
        .de_o          (de),
        .frame_start_o (fs),
        .irq_o         (irq),
        .data_pol_o    (dpol),
        .pclk_pol_o    (cpol)
    );

    // columns: hs hb ha hf vs vb va vf pol expected_de_per_frame
    localparam int CFG [3][10] = '{
        '{1, 1, 3, 0, 0, 0, 2, 0, 31, 12},
        '{2, 0, 1, 1, 1, 0, 1, 0,  0,  4},
        '{0, 0, 0, 0, 0, 0, 0, 0, 31,  1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'h0, v); chk("R1 cmd", v, 0);
        rd(4'h1, v); chk("R1 pol", v, 31);
        rd(4'h2, v); chk("R1 mask", v, 0);
        rd(4'h3, v); chk("R1 status", v, 0);
        rd(4'hC, v); chk("R1 timing", v, 0);
        chk("R1 hsync", int'(hsync), 0);
        chk("R1 vsync", int'(vsync), 0);
        chk("R1 de", int'(de), 0);
        chk("R1 fs", int'(fs), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R6 reset dpol", int'(dpol), 1);

        // table-driven raster checks
        for (int r = 0; r < 3; r++) begin
            int htot, vtot, decnt, hact0, vact0, pol;
            wr(4'h0, 0);
            for (int k = 0; k < 8; k++) wr(4'(8 + k), CFG[r][k]);
            wr(4'h1, CFG[r][8]);
            rd(4'hA, v); chk("R2 readback hact", v, CFG[r][2]);
            rd(4'hE, v); chk("R2 readback vact", v, CFG[r][6]);
            wr(4'h0, 1);
            htot  = CFG[r][0] + CFG[r][1] + CFG[r][2] + CFG[r][3] + 4;
            vtot  = CFG[r][4] + CFG[r][5] + CFG[r][6] + CFG[r][7] + 4;
            hact0 = CFG[r][0] + CFG[r][1] + 2;
            vact0 = CFG[r][4] + CFG[r][5] + 2;
            pol   = CFG[r][8];
            decnt = 0;
            for (int t = 0; t < 2 * htot * vtot; t++) begin
                int h, vv;
                bit hs_a, vs_a, de_a;
                h  = t % htot;
                vv = (t / htot) % vtot;
                hs_a = (h <= CFG[r][0]);
                vs_a = (vv <= CFG[r][4]);
                de_a = (h >= hact0) && (h < hact0 + CFG[r][2] + 1) &&
                       (vv >= vact0) && (vv < vact0 + CFG[r][6] + 1);
                chk("R3 hsync", int'(hsync), int'(pol[0] ? hs_a : !hs_a));
                chk("R4 vsync", int'(vsync), int'(pol[1] ? vs_a : !vs_a));
                chk("R5 de", int'(de), int'(pol[2] ? de_a : !de_a));
                chk("R7 frame start", int'(fs), int'(h == 0 && vv == 0));
                if (t < htot * vtot && (de == pol[2])) decnt++;
                @(negedge clk);
            end
            chk("R5 de count", decnt, CFG[r][9]);
            chk("R6 data pol", int'(dpol), (pol >> 3) & 1);
            chk("R6 pclk pol", int'(cpol), (pol >> 4) & 1);
        end

        // running config 2, mask 0, status set
        rd(4'h3, v); chk("R9 status set by frames", v, 1);
        chk("R10 irq masked", int'(irq), 0);

        // stop with active-low outputs
        wr(4'h1, 0);
        wr(4'h0, 0);
        for (int c = 0; c < 3; c++) begin
            chk("R8 idle hsync", int'(hsync), 1);
            chk("R8 idle vsync", int'(vsync), 1);
            chk("R8 idle de", int'(de), 1);
            chk("R8 idle fs", int'(fs), 0);
            @(negedge clk);
        end
        wr(4'h4, 0);
        rd(4'h3, v); chk("R11 zero clear ignored", v, 1);
        wr(4'h4, 1);
        rd(4'h3, v); chk("R11 clear", v, 0);
        repeat (40) @(negedge clk);
        rd(4'h3, v); chk("R8 no status while idle", v, 0);
        wr(4'h2, 1);
        chk("R10 irq low with status 0", int'(irq), 0);
        wr(4'h1, 31);

        // restart and collide a clear with the first frame start
        wr(4'h0, 1);
        chk("R7 restart at zero", int'(fs), 1);
        rd(4'h3, v); chk("R9 status not yet set", v, 0);
        wr_en = 1'b1; addr = 4'h4; wdata = 1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(4'h3, v); chk("R12 set wins over clear", v, 1);
        chk("R10 irq with mask", int'(irq), 1);

        // clear away from a frame start, then wait for the next frame
        wr(4'h4, 1);
        rd(4'h3, v); chk("R11 clear while running", v, 0);
        chk("R10 irq drops", int'(irq), 0);
        begin
            int waitc;
            waitc = 0;
            while (fs !== 1'b1 && waitc < 100) begin
                @(negedge clk);
                waitc++;
            end
            chk("R7 frame period", waitc, 13);
        end
        @(negedge clk);
        rd(4'h3, v); chk("R9 status after frame", v, 1);
        chk("R10 irq after frame", int'(irq), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule